// File: doc/BRIEF.md
# High-Resolution Sprite Pixel Decoder

This block takes one sprite graphics byte together with its 3-bit palette field, its sub-mode and a background color index. It turns that byte into four pixel-pair slots for a line buffer that runs at twice the coarse horizontal resolution. Each slot carries two fine half-pixel color indices, left then right, and a flag that marks the whole pair as transparent. The slots leave the block one per clock, marked by a valid strobe.

The four sub-modes trade pixels per byte against colors and palette reach. Two of them give one bit per fine pixel. The other two give one value per coarse pixel, so both halves of the pair carry the same color. Transparency is always decided on a whole coarse pair. Inside a visible pair, a half whose color is zero shows the background index and does not let the layer underneath through. A color register index is 0 for background storage, or 3·palette + color for palette colors 1 to 3, which covers 25 registers.

Top module: `hrsp_decoder`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 at once, without waiting for a clock, and `in_ready` is 0. Within three clocks after `rst_n` rises, `in_ready` is 1 and `out_valid` stays 0.
- R2: A byte is accepted on a rising edge where `in_valid` and `in_ready` are both 1. It produces exactly four slots, with `out_valid` high on the four following cycles. Slot 0 comes first and is the leftmost pair.
- R3: `in_ready` is 0 during slots 0 to 2, and any byte offered then is ignored. `in_ready` is 1 during slot 3, so a new byte can be taken on the edge that ends slot 3 and its slot 0 follows with no gap.
- R4: When `in_mode` is 2'b00 (one bit per fine pixel), slot k takes its left half from byte bit 7-2k and its right half from bit 6-2k. A set bit gives color 1 and a clear bit gives color 0. The palette is `in_pal`.
- R5: When `in_mode` is 2'b10 (four colors per coarse pixel), slot k takes its color from byte bits [7-2k:6-2k] and uses it for both halves. The palette is `in_pal`.
- R6: When `in_mode` is 2'b01 (two colors per coarse pixel), slot k is on when byte bit 7-k is set. An on slot uses color 2 in both halves. The palette is {byte bit 3-k, `in_pal[1:0]`}.
- R7: When `in_mode` is 2'b11 (shared-bit mode), a set left bit (byte bit 7-2k) gives color 2 and a set right bit (byte bit 6-2k) gives color 1. The palette is {`in_pal[2]`, 0, byte bit 3-k}, so a sprite reaches only two palettes.
- R8: A slot has `out_transp` set exactly when both halves have color 0. A transparent slot drives both indices to 0.
- R9: In a slot that is not transparent, a half with color 0 drives `in_bg`, the value captured with the byte.
- R10: A half with color c from 1 to 3 and palette p drives index 3·p + c. The range is 1 to 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The block can take a byte on this edge |
| in_byte | input | 8 | Sprite graphics byte |
| in_pal | input | 3 | Palette field |
| in_mode | input | 2 | Sub-mode: bit 1 selects the two-bit family, bit 0 selects the alternate mode |
| in_bg | input | 5 | Background color index |
| out_valid | output | 1 | A slot is on the outputs |
| out_transp | output | 1 | The whole pair is transparent |
| out_left | output | 5 | Left half color index |
| out_right | output | 5 | Right half color index |

## Verification
Two functions can fall in the same cycle: emitting slot 3 of one byte and accepting the next byte. The vector table sends every byte back to back, offering each new byte on the cycle where the previous byte's last slot is showing. Each run is then judged on two points: all four slots of the earlier byte must match the model, and the new byte's slot 0 must appear on the very next cycle. A separate directed test offers a different byte during slots 0 to 2. It then checks that the slots still match the first byte and that `out_valid` drops after slot 3.

// File: rtl/hrsp_pkg.sv
package hrsp_pkg;
  localparam int DATA_W = 8;
  localparam int PAL_W  = 3;
  localparam int IDX_W  = 5;

  // bit 1: two-bit family, bit 0: alternate mode of the family
  typedef enum logic [1:0] {
    M_FINE1  = 2'b00,
    M_COARSE2 = 2'b01,
    M_COARSE4 = 2'b10,
    M_SHARED = 2'b11
  } hr_mode_e;
endpackage

// File: rtl/hrsp_rst_sync.sv
module hrsp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/hrsp_seq.sv
module hrsp_seq #(
  parameter int SLOTS  = 4,
  parameter int BUND_W = 18,
  localparam int CW    = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BUND_W-1:0] in_bund,
  output logic              rdy,
  output logic              busy,
  output logic [CW-1:0]     cnt,
  output logic [BUND_W-1:0] hold
);
  logic              busy_d;
  logic [CW-1:0]     cnt_d;
  logic [BUND_W-1:0] hold_d;
  logic              last, take;

  assign last = busy && (cnt == CW'(SLOTS - 1));
  assign rdy  = !busy || last;
  assign take = in_valid && rdy;

  always_comb begin
    busy_d = busy;
    cnt_d  = cnt;
    hold_d = hold;
    if (take) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      hold_d = in_bund;
    end else if (last) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy) begin
      cnt_d  = cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      hold <= '0;
    end else begin
      busy <= busy_d;
      cnt  <= cnt_d;
      hold <= hold_d;
    end
  end
endmodule

// File: rtl/hrsp_unpack.sv
module hrsp_unpack
  import hrsp_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int PW  = PAL_W,
  parameter int IW  = IDX_W,
  localparam int SLOTS = DW / 2,
  localparam int NIB   = DW / 2
) (
  input  logic [DW-1:0]               gfx,
  input  logic [PW-1:0]               pal,
  input  logic [1:0]                  mode,
  input  logic [IW-1:0]               bg,
  output logic [SLOTS-1:0]            transp,
  output logic [SLOTS-1:0][IW-1:0]    lidx,
  output logic [SLOTS-1:0][IW-1:0]    ridx
);
  function automatic logic [IW-1:0] to_idx(input logic [PW-1:0] p,
                                           input logic [1:0] c,
                                           input logic [IW-1:0] b);
    if (c == 2'd0) return b;
    return IW'(p) * IW'(3) + IW'(c);
  endfunction

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    localparam int HI = DW - 1 - 2 * g;
    localparam int LO = HI - 1;
    localparam int CB = DW - 1 - g;
    localparam int NB = NIB - 1 - g;
    logic [1:0]    cl, cr;
    logic [PW-1:0] pl;

    always_comb begin
      cl = 2'd0;
      cr = 2'd0;
      pl = pal;
      unique case (hr_mode_e'(mode))
        M_FINE1: begin
          cl = {1'b0, gfx[HI]};
          cr = {1'b0, gfx[LO]};
        end
        M_COARSE2: begin
          cl = gfx[CB] ? 2'd2 : 2'd0;
          cr = cl;
          pl = {gfx[NB], pal[PW-2:0]};
        end
        M_COARSE4: begin
          cl = gfx[HI:LO];
          cr = cl;
        end
        M_SHARED: begin
          cl = gfx[HI] ? 2'd2 : 2'd0;
          cr = gfx[LO] ? 2'd1 : 2'd0;
          pl = {pal[PW-1], {(PW-2){1'b0}}, gfx[NB]};
        end
      endcase
    end

    assign transp[g] = (cl == 2'd0) && (cr == 2'd0);
    assign lidx[g]   = transp[g] ? '0 : to_idx(pl, cl, bg);
    assign ridx[g]   = transp[g] ? '0 : to_idx(pl, cr, bg);
  end
endmodule

// File: rtl/hrsp_decoder.sv
module hrsp_decoder
  import hrsp_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PAL_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_byte,
  input  logic [PW-1:0] in_pal,
  input  logic [1:0]    in_mode,
  input  logic [IW-1:0] in_bg,
  output logic          out_valid,
  output logic          out_transp,
  output logic [IW-1:0] out_left,
  output logic [IW-1:0] out_right
);
  localparam int SLOTS  = DW / 2;
  localparam int CW     = $clog2(SLOTS);
  localparam int BUND_W = 2 + PW + DW + IW;

  logic                      rst_q, rdy, busy;
  logic [CW-1:0]             cnt;
  logic [BUND_W-1:0]         hold;
  logic [1:0]                h_mode;
  logic [PW-1:0]             h_pal;
  logic [DW-1:0]             h_byte;
  logic [IW-1:0]             h_bg;
  logic [SLOTS-1:0]          transp;
  logic [SLOTS-1:0][IW-1:0]  lidx, ridx;

  hrsp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q)
  );

  hrsp_seq #(.SLOTS(SLOTS), .BUND_W(BUND_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_q),
    .in_valid (in_valid),
    .in_bund  ({in_mode, in_pal, in_byte, in_bg}),
    .rdy      (rdy),
    .busy     (busy),
    .cnt      (cnt),
    .hold     (hold)
  );

  assign {h_mode, h_pal, h_byte, h_bg} = hold;

  hrsp_unpack #(.DW(DW), .PW(PW), .IW(IW)) u_unpack (
    .gfx    (h_byte),
    .pal    (h_pal),
    .mode   (h_mode),
    .bg     (h_bg),
    .transp (transp),
    .lidx   (lidx),
    .ridx   (ridx)
  );

  assign in_ready   = rdy && rst_q;
  assign out_valid  = busy;
  assign out_transp = busy && transp[cnt];
  assign out_left   = busy ? lidx[cnt] : '0;
  assign out_right  = busy ? ridx[cnt] : '0;
endmodule

// File: rtl/hrsp_decoder_chk.sv
module hrsp_decoder_chk #(
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_transp,
  input logic [IW-1:0] out_left,
  input logic [IW-1:0] out_right
);
  logic [2:0] seen;
  logic       acc;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen <= 3'd0;
    else if (acc)       seen <= 3'd0;
    else if (out_valid) seen <= seen + 3'd1;
  end

  // R2
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);
  // R2
  slot_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> seen <= 3'd3);
  // R3
  ready_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && in_ready) |-> seen == 3'd3);
  // R2
  stop_after_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen == 3'd3 && !acc) |=> !out_valid);
  // R8
  transp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_transp |-> (out_left == '0 && out_right == '0));
  // R8
  transp_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_transp);
endmodule

bind hrsp_decoder hrsp_decoder_chk #(.IW(IW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_transp (out_transp),
  .out_left   (out_left),
  .out_right  (out_right)
);

// File: tb/hrsp_decoder_tb.sv
module hrsp_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready;
  logic [7:0] in_byte;
  logic [2:0] in_pal;
  logic [1:0] in_mode;
  logic [4:0] in_bg;
  logic       out_valid, out_transp;
  logic [4:0] out_left, out_right;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hrsp_decoder u_dut (.*);

  // {mode, palette, byte, background}
  localparam logic [17:0] VEC [0:11] = '{
    {2'b00, 3'd5, 8'h00, 5'd3},  {2'b00, 3'd1, 8'hFF, 5'd0},
    {2'b00, 3'd7, 8'h55, 5'd9},  {2'b10, 3'd2, 8'hE4, 5'd30},
    {2'b10, 3'd7, 8'hFF, 5'd0},  {2'b10, 3'd0, 8'h1B, 5'd4},
    {2'b01, 3'd3, 8'hF0, 5'd0},  {2'b01, 3'd6, 8'h5A, 5'd2},
    {2'b01, 3'd7, 8'h0F, 5'd1},  {2'b11, 3'd4, 8'hA5, 5'd7},
    {2'b11, 3'd1, 8'h5F, 5'd11}, {2'b11, 3'd6, 8'h00, 5'd5}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] model(input int m, input int p, input int b,
                                        input int bg, input int k);
    int cl, cr, pp;
    case (m)
      0: begin cl = (b >> (7 - 2*k)) & 1; cr = (b >> (6 - 2*k)) & 1; pp = p; end
      1: begin cl = ((b >> (7 - k)) & 1) * 2; cr = cl; pp = (p & 3) | (((b >> (3 - k)) & 1) << 2); end
      2: begin cl = (b >> (6 - 2*k)) & 3; cr = cl; pp = p; end
      default: begin cl = ((b >> (7 - 2*k)) & 1) * 2; cr = (b >> (6 - 2*k)) & 1; pp = (p & 4) | ((b >> (3 - k)) & 1); end
    endcase
    if (cl == 0 && cr == 0) return 11'h400;
    return {1'b0, 5'((cl == 0) ? bg : 3*pp + cl), 5'((cr == 0) ? bg : 3*pp + cr)};
  endfunction

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'b00: return "R2 R4 R9 R10";
      2'b10: return "R2 R5 R10";
      2'b01: return "R2 R6 R10";
      default: return "R2 R7 R9 R10";
    endcase
  endfunction

  // starts and ends at a negedge
  task automatic send(input logic [17:0] v);
    logic [10:0] e, got;
    chk(in_ready === 1'b1, "R3 ready", int'(in_ready), 1);
    {in_mode, in_pal, in_byte, in_bg} = v;
    in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      e = model(int'(v[17:16]), int'(v[15:13]), int'(v[12:5]), int'(v[4:0]), k);
      got = {out_transp, out_left, out_right};
      chk(out_valid === 1'b1 && got === e, e[10] ? "R8 transparent" : tag_of(v[17:16]),
          int'(got), int'(e));
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_byte = '0; in_pal = '0; in_mode = '0; in_bg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b0, "R1 in reset", int'({out_valid, in_ready}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R1 after release", int'({out_valid, in_ready}), 1);

    // table, sent back to back: new byte taken while slot 3 shows (R3)
    for (int i = 0; i < 12; i++) send(VEC[i]);
    @(negedge clk);
    chk(out_valid === 1'b0, "R2 idle after last", int'(out_valid), 0);

    // hand values: R10 top index, R9 background in visible pair, R6 off slots
    in_mode = 2'b10; in_pal = 3'd7; in_byte = 8'hFF; in_bg = 5'd0; in_valid = 1'b1;
    @(posedge clk); @(negedge clk); in_valid = 1'b0;
    chk(out_left === 5'd24 && out_right === 5'd24, "R10 index 24", int'(out_left), 24);
    repeat (3) @(negedge clk);
    in_mode = 2'b00; in_pal = 3'd2; in_byte = 8'h81; in_bg = 5'd31; in_valid = 1'b1;
    @(posedge clk); @(negedge clk); in_valid = 1'b0;
    chk(out_left === 5'd7 && out_right === 5'd31 && out_transp === 1'b0, "R9 bg half",
        int'({out_left, out_right}), int'({5'd7, 5'd31}));
    @(negedge clk);
    chk(out_transp === 1'b1, "R8 zero pair", int'(out_transp), 1);
    repeat (2) @(negedge clk);
    chk(out_left === 5'd31 && out_right === 5'd7, "R4 last slot", int'({out_left, out_right}),
        int'({5'd31, 5'd7}));

    // R3: byte offered mid-stream is ignored
    in_mode = 2'b01; in_pal = 3'd3; in_byte = 8'hF0; in_bg = 5'd0; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_mode = 2'b10; in_pal = 3'd1; in_byte = 8'h55; in_bg = 5'd6;
    for (int k = 0; k < 4; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 2) in_valid = 1'b0;
      if (k < 3) chk(in_ready === 1'b0, "R3 not ready", int'(in_ready), 0);
      chk(out_left === 5'd11 && out_right === 5'd11, "R3 ignored byte", int'(out_left), 11);
    end
    @(negedge clk);
    chk(out_valid === 1'b0, "R3 ignored no extra", int'(out_valid), 0);

    // R1: reset in mid-stream clears at once
    send(VEC[3]);
    in_mode = 2'b00; in_byte = 8'hFF; in_valid = 1'b1;
    @(posedge clk); @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0; #1;
    chk(out_valid === 1'b0, "R1 async clear", int'(out_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R1 recovered", int'({out_valid, in_ready}), 1);
    send(VEC[9]);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule